// File: doc/BRIEF.md
# Processor Flag Register with Event-Only Power Flags

This block holds the condition flags of a small 8-bit processor core in one byte. The carry, half-carry (auxiliary carry), zero and overflow flags can be written by software through the data-memory write port, at the register's address. The arithmetic unit can also load each of these four flags on its own, through a separate enable for each flag. The byte is always visible on a read output, so the core's read multiplexer can return it.

Two further flags are kept apart from software. The power-down flag and the watchdog-expired flag change only through dedicated strobes: the halt instruction, the clear-watchdog instruction and the watchdog timer expiring. Power-up reset also clears them. A software write never reaches these two bits. The core does not save this register on its own when it takes an interrupt or enters a subroutine. Software must save and restore it where that matters.

Top module: `flag_status_reg`

## Requirements
- R1: After reset (`rst_n` low) `status_o` reads 0x00, so every flag, including power-down and watchdog-expired, is clear.
- R2: A write with `wr_en` high and `wr_addr` equal to `REG_ADDR` (default 0x0A) loads `wr_data[3:0]` into the flags on the next clock. The bit layout is: carry in bit 0, half-carry in bit 1, zero in bit 2, overflow in bit 3.
- R3: A write to any other address leaves every bit of `status_o` unchanged.
- R4: A software write never alters bit 4 (power-down) or bit 5 (watchdog-expired), whatever `wr_data[5:4]` holds.
- R5: For each of the four arithmetic flags, `alu_flag_we[i]` high loads `alu_flag_val[i]` into bit i on the next clock. Flags whose enable is low keep their value. Index i follows the layout given in R2.
- R6: When a software write and an arithmetic update fall in the same cycle, each flag with its arithmetic enable high takes the arithmetic value. The other flags take the written value.
- R7: A `halt_stb` pulse sets power-down (bit 4) and clears watchdog-expired (bit 5).
- R8: A `clrwdt_stb` pulse clears both power-down and watchdog-expired.
- R9: A `wdt_tmo` pulse sets watchdog-expired and leaves power-down unchanged.
- R10: When `wdt_tmo` coincides with `halt_stb` or `clrwdt_stb`, watchdog-expired ends set. Power-down follows the halt or clear-watchdog rule.
- R11: When `halt_stb` and `clrwdt_stb` coincide, the halt outcome applies: power-down set, watchdog-expired clear.
- R12: Bits 6 and 7 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Data-memory write strobe |
| wr_addr | input | ADDR_W (8) | Data-memory write address |
| wr_data | input | DATA_W (8) | Data-memory write data |
| alu_flag_we | input | 4 | Per-flag load enables from the arithmetic unit (C, AC, Z, OV) |
| alu_flag_val | input | 4 | Flag values from the arithmetic unit, same order |
| halt_stb | input | 1 | Halt instruction executed |
| clrwdt_stb | input | 1 | Clear-watchdog instruction executed |
| wdt_tmo | input | 1 | Watchdog timer expired |
| status_o | output | DATA_W (8) | Current register contents |

## Verification
Two pairs of paths can act in the same cycle. A software store and an arithmetic flag update can both target the carry, half-carry, zero and overflow bits. The watchdog expiry can land in the same cycle as a halt or clear-watchdog strobe. The bench drives each pair in one cycle with enable masks and data chosen so that every flag shows which source won. It then compares the byte read on the next cycle with the value the priority rules give.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
   // Bit positions within the flag byte
   localparam int unsigned CARRY_BIT = 0;
   localparam int unsigned HALF_BIT  = 1;
   localparam int unsigned ZERO_BIT  = 2;
   localparam int unsigned OVF_BIT   = 3;
   localparam int unsigned PWRDN_BIT = 4;
   localparam int unsigned WDEXP_BIT = 5;
   localparam int unsigned ARITH_N   = 4;   // flags software and ALU may load
   localparam int unsigned USED_BITS = 6;

   typedef struct packed {
      logic pwrdn;
      logic wdexp;
   } pwr_flags_t;
endpackage

// File: rtl/stsreg_dff.sv
module stsreg_dff #(
   parameter int unsigned W        = 1,
   parameter bit          ASYNC    = 1'b1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (ASYNC) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/stsreg_arith_next.sv
module stsreg_arith_next #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] cur,
   input  logic         sw_hit,
   input  logic [N-1:0] sw_val,
   input  logic [N-1:0] alu_we,
   input  logic [N-1:0] alu_val,
   output logic [N-1:0] nxt
);
   // Per flag: arithmetic update outranks a software store
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_comb begin
         if (alu_we[i])   nxt[i] = alu_val[i];
         else if (sw_hit) nxt[i] = sw_val[i];
         else             nxt[i] = cur[i];
      end
   end
endmodule

// File: rtl/stsreg_power_next.sv
module stsreg_power_next
   import stsreg_pkg::*;
(
   input  pwr_flags_t cur,
   input  logic       halt_stb,
   input  logic       clrwdt_stb,
   input  logic       wdt_tmo,
   output pwr_flags_t nxt
);
   always_comb begin
      // power-down: halt sets, clear-watchdog clears, halt dominates
      if (halt_stb)        nxt.pwrdn = 1'b1;
      else if (clrwdt_stb) nxt.pwrdn = 1'b0;
      else                 nxt.pwrdn = cur.pwrdn;
      // watchdog-expired: expiry sets and dominates, either instruction clears
      if (wdt_tmo)                      nxt.wdexp = 1'b1;
      else if (halt_stb || clrwdt_stb)  nxt.wdexp = 1'b0;
      else                              nxt.wdexp = cur.wdexp;
   end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
   import stsreg_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 'h0A,
   parameter bit                ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [3:0]        alu_flag_we,
   input  logic [3:0]        alu_flag_val,
   input  logic              halt_stb,
   input  logic              clrwdt_stb,
   input  logic              wdt_tmo,
   output logic [DATA_W-1:0] status_o
);
   localparam int unsigned PAD_W = DATA_W - USED_BITS;

   generate
      if (DATA_W < USED_BITS) begin : g_bad_width
         $error("flag_status_reg: DATA_W must hold at least six flags");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("flag_status_reg: ADDR_W must be positive");
      end
   endgenerate

   logic                sw_hit;
   logic [ARITH_N-1:0]  arith_q, arith_d;
   pwr_flags_t          pwr_q, pwr_d;
   logic [DATA_W-1:0]   unused_wr_hi;

   assign sw_hit       = wr_en && (wr_addr == REG_ADDR);
   assign unused_wr_hi = wr_data;

   stsreg_arith_next #(.N(ARITH_N)) u_arith (
      .cur     (arith_q),
      .sw_hit  (sw_hit),
      .sw_val  (wr_data[ARITH_N-1:0]),
      .alu_we  (alu_flag_we),
      .alu_val (alu_flag_val),
      .nxt     (arith_d)
   );

   stsreg_power_next u_power (
      .cur        (pwr_q),
      .halt_stb   (halt_stb),
      .clrwdt_stb (clrwdt_stb),
      .wdt_tmo    (wdt_tmo),
      .nxt        (pwr_d)
   );

   stsreg_dff #(.W(ARITH_N), .ASYNC(ASYNC_RST)) u_arith_q (
      .clk (clk), .rst_n (rst_n), .d (arith_d), .q (arith_q)
   );

   stsreg_dff #(.W(2), .ASYNC(ASYNC_RST)) u_pwr_q (
      .clk (clk), .rst_n (rst_n), .d (pwr_d), .q (pwr_q)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign status_o = {{PAD_W{1'b0}}, pwr_q.wdexp, pwr_q.pwrdn, arith_q};
      end else begin : g_nopad
         assign status_o = {pwr_q.wdexp, pwr_q.pwrdn, arith_q};
      end
   endgenerate
endmodule

// File: rtl/stsreg_checker.sv
module stsreg_checker
   import stsreg_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h0A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [3:0]        alu_flag_we,
   input logic [3:0]        alu_flag_val,
   input logic              halt_stb,
   input logic              clrwdt_stb,
   input logic              wdt_tmo,
   input logic [DATA_W-1:0] status_o
);
   logic hit;
   assign hit = wr_en && (wr_addr == REG_ADDR);

   for (genvar i = 0; i < 4; i++) begin : g_fl
      a_r5_alu_load: assert property (@(posedge clk) disable iff (!rst_n)
         alu_flag_we[i] |=> status_o[i] == $past(alu_flag_val[i]));
      a_r6_sw_when_no_alu: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && !alu_flag_we[i]) |=> status_o[i] == $past(wr_data[i]));
      a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (!hit && !alu_flag_we[i]) |=> $stable(status_o[i]));
   end

   a_r4_power_bits_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_stb && !clrwdt_stb && !wdt_tmo) |=> $stable(status_o[WDEXP_BIT:PWRDN_BIT]));
   a_r7_halt_sets_pd: assert property (@(posedge clk) disable iff (!rst_n)
      halt_stb |=> status_o[PWRDN_BIT]);
   a_r7_halt_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_stb && !wdt_tmo) |=> !status_o[WDEXP_BIT]);
   a_r8_clrwdt_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clrwdt_stb && !halt_stb && !wdt_tmo) |=> status_o[WDEXP_BIT:PWRDN_BIT] == 2'b00);
   a_r9_tmo_keeps_pd: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_tmo && !halt_stb && !clrwdt_stb) |=> $stable(status_o[PWRDN_BIT]));
   a_r10_tmo_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_tmo |=> status_o[WDEXP_BIT]);
   a_r12_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[DATA_W-1:USED_BITS] == '0);
endmodule

bind flag_status_reg stsreg_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .alu_flag_we(alu_flag_we), .alu_flag_val(alu_flag_val), .halt_stb(halt_stb),
   .clrwdt_stb(clrwdt_stb), .wdt_tmo(wdt_tmo), .status_o(status_o)
);

// File: tb/tb_flag_status_reg.sv
`timescale 1ns/1ps
module tb_flag_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] alu_flag_we = '0;
   logic [3:0] alu_flag_val = '0;
   logic       halt_stb = 1'b0;
   logic       clrwdt_stb = 1'b0;
   logic       wdt_tmo = 1'b0;
   logic [7:0] status_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   flag_status_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alu_flag_we(alu_flag_we), .alu_flag_val(alu_flag_val), .halt_stb(halt_stb),
      .clrwdt_stb(clrwdt_stb), .wdt_tmo(wdt_tmo), .status_o(status_o)
   );

   task automatic check(input string tag, input logic [7:0] exp);
      n_chk++;
      if (status_o !== exp) begin
         n_bad++;
         $display("FAIL %s: status=0x%02h expected 0x%02h", tag, status_o, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 0; wr_addr = 0; wr_data = 0; alu_flag_we = 0; alu_flag_val = 0;
      halt_stb = 0; clrwdt_stb = 0; wdt_tmo = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
      idle_inputs();
   endtask

   task automatic t_reset();
      rst_n = 0; repeat (2) @(posedge clk); #1; rst_n = 1;
      check("R1 reset", 8'h00);
   endtask

   task automatic t_sw_write();
      wr_en = 1; wr_addr = 8'h0A; wr_data = 8'hFF; tick();
      check("R2/R4/R12 write all ones", 8'h0F);
      wr_en = 1; wr_addr = 8'h0A; wr_data = 8'h05; tick();
      check("R2 write 0x05", 8'h05);
   endtask

   task automatic t_other_addr();
      wr_en = 1; wr_addr = 8'h0B; wr_data = 8'hFA; tick();
      check("R3 other address", 8'h05);
      wr_en = 0; wr_addr = 8'h0A; wr_data = 8'h00; tick();
      check("R3 strobe low", 8'h05);
   endtask

   task automatic t_halt();
      halt_stb = 1; tick();
      check("R7 halt", 8'h15);
      wr_en = 1; wr_addr = 8'h0A; wr_data = 8'h20; tick();
      check("R4 write cannot touch power bits", 8'h10);
   endtask

   task automatic t_timeout();
      wdt_tmo = 1; tick();
      check("R9 expiry keeps power-down", 8'h30);
      wr_en = 1; wr_addr = 8'h0A; wr_data = 8'h00; tick();
      check("R4 write 0 keeps both set", 8'h30);
   endtask

   task automatic t_clrwdt();
      clrwdt_stb = 1; tick();
      check("R8 clear watchdog", 8'h00);
   endtask

   task automatic t_alu();
      alu_flag_we = 4'b0101; alu_flag_val = 4'b1111; tick();
      check("R5 masked load", 8'h05);
      alu_flag_we = 4'b1001; alu_flag_val = 4'b1000; tick();
      check("R5 clear carry set ovf", 8'h0C);
   endtask

   task automatic t_conflict();
      wr_en = 1; wr_addr = 8'h0A; wr_data = 8'h0A;
      alu_flag_we = 4'b0011; alu_flag_val = 4'b0001; tick();
      check("R6 alu vs write", 8'h09);
   endtask

   task automatic t_events_combo();
      halt_stb = 1; wdt_tmo = 1; tick();
      check("R10 halt with expiry", 8'h39);
      clrwdt_stb = 1; wdt_tmo = 1; tick();
      check("R10 clear with expiry", 8'h29);
      halt_stb = 1; clrwdt_stb = 1; tick();
      check("R11 halt with clear", 8'h19);
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      #1;
      t_reset();
      t_sw_write();
      t_other_addr();
      t_halt();
      t_timeout();
      t_clrwdt();
      t_alu();
      t_conflict();
      t_events_combo();
      halt_stb = 1; tick();
      t_reset();   // R1 again from a non-zero state
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule